// File: doc/BRIEF.md
# Push-Button Interrupt Request Generator

This block turns a raw, asynchronous push-button signal into a single interrupt request per press for a processor. The button is first brought into the system clock domain through a short register chain. A debounce filter then accepts a new button level only after the synchronized input has held that level for a set number of clocks.

A change of the filtered level from released to pressed produces a one-cycle event pulse. That pulse sets a sticky pending flag, which stays high until the processor raises the clear input. Holding the button down, releasing it, or contact bounce on the way up or down produces no further events.

Top module: `btn_irq_gen`

## Requirements
- R1: Reset is active high and asynchronous. While it is high, `irqPulse` and `irqPending` read 0 without waiting for a clock edge, and the synchronizer, filter and edge history are cleared.
- R2: A released-to-pressed change of the filtered level gives `irqPulse` = 1 for exactly one cycle. After a clean press, the pulse is high in the cycle that follows clock edge number SYNC_STAGES + STABLE_CLKS + 1, counted from the first edge that samples the new raw level.
- R3: One press gives exactly one pulse, however long the button is held.
- R4: With no pulse in the same cycle, `irqClr` = 1 at a clock edge sets `irqPending` to 0 at that edge.
- R5: A pulse sets `irqPending` to 1 at the next edge. If the clear and the pulse meet at the same edge, the set wins.
- R6: A pressed-to-released change of the filtered level produces no pulse.
- R7: The filtered level changes only after the synchronized input has differed from it at STABLE_CLKS consecutive edges. A raw glitch of fewer than STABLE_CLKS cycles, whether in the idle-low state or while the button is held, produces no pulse.
- R8: Without a clear, `irqPending` stays at 1, including through further presses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| btnRaw | input | 1 | Unsynchronized button level, 1 = pressed |
| irqClr | input | 1 | Clear request for the pending flag |
| irqPulse | output | 1 | One-cycle press event |
| irqPending | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with SYNC_STAGES = 3 and STABLE_CLKS = 4. A filter window this short makes it possible to sweep every raw pulse width from 1 to STABLE_CLKS + 2 cycles, both in the idle-low state and as dips during a held press. That puts both sides of the acceptance threshold in range, and the exact event latency is checked against 1 + SYNC_STAGES + STABLE_CLKS. Held presses of several lengths, a clear that lands on the same edge as the event, and a reset that arrives mid-press finish the coverage.

// File: rtl/btn_irq_pkg.sv
package btn_irq_pkg;

  // Strobes from the control decode to the datapath registers
  typedef struct packed {
    logic cntZero;   // restart the stability counter
    logic cntInc;    // advance the stability counter
    logic lvlLoad;   // accept the synchronized level as filtered level
    logic evtFire;   // raise the one-cycle event pulse
    logic pendSet;   // set the pending flag
    logic pendClr;   // clear the pending flag
  } irq_strobe_t;

endpackage

// File: rtl/btn_irq_dp.sv
module btn_irq_dp
  import btn_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int STABLE_CLKS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        btnRaw,
  input  irq_strobe_t strb,
  output logic        syncBit,
  output logic        debLvl,
  output logic        lvlPrev,
  output logic        cntAtLimit,
  output logic        irqPulse,
  output logic        irqPending
);

  localparam int CNT_W = (STABLE_CLKS > 1) ? $clog2(STABLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CLKS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       stabCnt;

  // Synchronizer chain, one register per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gHead
      always_ff @(posedge clk or posedge rst) begin
        if (rst) syncQ[0] <= 1'b0;
        else     syncQ[0] <= btnRaw;
      end
    end else begin : gTail
      always_ff @(posedge clk or posedge rst) begin
        if (rst) syncQ[g] <= 1'b0;
        else     syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign syncBit    = syncQ[SYNC_STAGES-1];
  assign cntAtLimit = (stabCnt == CNT_LAST);

  // Stability counter and filtered level
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stabCnt <= '0;
      debLvl  <= 1'b0;
    end else begin
      if (strb.cntZero)     stabCnt <= '0;
      else if (strb.cntInc) stabCnt <= stabCnt + 1'b1;
      if (strb.lvlLoad)     debLvl  <= syncBit;
    end
  end

  // Edge history, event pulse and sticky request
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lvlPrev    <= 1'b0;
      irqPulse   <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      lvlPrev  <= debLvl;
      irqPulse <= strb.evtFire;
      if (strb.pendSet)      irqPending <= 1'b1;
      else if (strb.pendClr) irqPending <= 1'b0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);                                       // R2
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> (lvlPrev && !$past(lvlPrev)));                    // R6
  AST_PEND_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> irqPending);                                      // R5
  AST_PEND_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(irqPending) |-> $past(irqPulse));                        // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irqPending && !strb.pendClr) |=> irqPending);                 // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    stabCnt <= CNT_LAST);                                          // R7
  AST_LVL_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(debLvl) |-> (debLvl == $past(syncBit)));              // R7

endmodule

// File: rtl/btn_irq_ctrl.sv
module btn_irq_ctrl
  import btn_irq_pkg::*;
(
  input  logic        syncBit,
  input  logic        debLvl,
  input  logic        lvlPrev,
  input  logic        cntAtLimit,
  input  logic        irqPulse,
  input  logic        irqClr,
  output irq_strobe_t strb
);

  always_comb begin
    strb = '0;
    // Filter decision: restart while agreeing, accept at end of window
    if (syncBit == debLvl) begin
      strb.cntZero = 1'b1;
    end else if (cntAtLimit) begin
      strb.cntZero = 1'b1;
      strb.lvlLoad = 1'b1;
    end else begin
      strb.cntInc = 1'b1;
    end
    // Released-to-pressed transition of the filtered level only
    strb.evtFire = debLvl & ~lvlPrev;
    // A pending set outranks a simultaneous clear
    strb.pendSet = irqPulse;
    strb.pendClr = irqClr & ~irqPulse;
  end

endmodule

// File: rtl/btn_irq_gen.sv
module btn_irq_gen
  import btn_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int STABLE_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  input  logic irqClr,
  output logic irqPulse,
  output logic irqPending
);

  irq_strobe_t irqStrb;
  logic        syncBit;
  logic        debLvl;
  logic        lvlPrev;
  logic        cntAtLimit;

  btn_irq_ctrl u_ctrl (
    .syncBit    (syncBit),
    .debLvl     (debLvl),
    .lvlPrev    (lvlPrev),
    .cntAtLimit (cntAtLimit),
    .irqPulse   (irqPulse),
    .irqClr     (irqClr),
    .strb       (irqStrb)
  );

  btn_irq_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .STABLE_CLKS (STABLE_CLKS)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .btnRaw     (btnRaw),
    .strb       (irqStrb),
    .syncBit    (syncBit),
    .debLvl     (debLvl),
    .lvlPrev    (lvlPrev),
    .cntAtLimit (cntAtLimit),
    .irqPulse   (irqPulse),
    .irqPending (irqPending)
  );

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irqClr && !irqPulse) |=> !irqPending);                        // R4

endmodule

// File: tb/sim_btn_irq_gen.sv
module sim_btn_irq_gen;

  localparam int SYNC   = 3;
  localparam int STABLE = 4;
  localparam int LAT    = 1 + SYNC + STABLE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnRaw = 1'b0;
  logic irqClr = 1'b0;
  logic irqPulse;
  logic irqPending;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  int evCount = 0;
  int firstAt = -1;
  int idx = 0;

  always #5 clk = ~clk;

  btn_irq_gen #(.SYNC_STAGES(SYNC), .STABLE_CLKS(STABLE)) u0 (
    .clk(clk), .rst(rst), .btnRaw(btnRaw), .irqClr(irqClr),
    .irqPulse(irqPulse), .irqPending(irqPending)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      finishRun();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance n falling edges, tallying event pulses
  task automatic stepN(int n);
    repeat (n) begin
      @(negedge clk);
      idx++;
      if (irqPulse) begin
        evCount++;
        if (firstAt < 0) firstAt = idx;
      end
    end
  endtask

  task automatic clearPend();
    irqClr = 1'b1;
    stepN(1);
    irqClr = 1'b0;
    chk(irqPending == 1'b0, "R4 clear", int'(irqPending), 0);
    evCount = 0; firstAt = -1; idx = 0;
  endtask

  // Raw high for w cycles from the idle-low state
  task automatic pressGlitch(int w);
    int expEv;
    clearPend();
    btnRaw = 1'b1;
    stepN(w);
    btnRaw = 1'b0;
    stepN(LAT + STABLE + 4);
    expEv = (w >= STABLE) ? 1 : 0;
    chk(evCount == expEv, "R7 glitch width", evCount, expEv);
    if (expEv == 1) chk(firstAt == LAT, "R2 latency", firstAt, LAT);
    chk(int'(irqPending) == expEv, "R5 pending set", int'(irqPending), expEv);
  endtask

  task automatic holdPress(int h);
    int c1;
    clearPend();
    btnRaw = 1'b1;
    stepN(h);
    c1 = evCount;
    chk(c1 == 1, "R3 one event per hold", c1, 1);
    btnRaw = 1'b0;
    stepN(LAT + 8);
    chk(evCount == c1, "R6 release silent", evCount, c1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irqPulse == 1'b0, "R1 reset pulse", int'(irqPulse), 0);
    chk(irqPending == 1'b0, "R1 reset pending", int'(irqPending), 0);
    rst = 1'b0;
    stepN(4);

    // R7 / R2: sweep glitch widths across the threshold
    for (int w = 1; w <= STABLE + 2; w++) pressGlitch(w);

    // R3 / R6: held presses of several lengths
    holdPress(LAT + 2);
    holdPress(60);
    holdPress(300);

    // R7: dips while held must not retrigger
    clearPend();
    btnRaw = 1'b1;
    stepN(LAT + 4);
    for (int g = 1; g < STABLE; g++) begin
      btnRaw = 1'b0;
      stepN(g);
      btnRaw = 1'b1;
      stepN(LAT + 4);
      chk(evCount == 1, "R7 held dip", evCount, 1);
    end
    btnRaw = 1'b0;
    stepN(LAT + 8);

    // R5: clear on the same edge as the event loses
    clearPend();
    btnRaw = 1'b1;
    while (!irqPulse && idx < 4 * LAT) stepN(1);
    chk(irqPulse == 1'b1, "R2 pulse seen", int'(irqPulse), 1);
    irqClr = 1'b1;
    stepN(1);
    chk(irqPending == 1'b1, "R5 set wins", int'(irqPending), 1);
    stepN(1);
    chk(irqPending == 1'b0, "R4 clear after", int'(irqPending), 0);
    irqClr = 1'b0;
    btnRaw = 1'b0;
    stepN(LAT + 8);

    // R8: flag stays through idle time and a second press
    pressGlitch(STABLE + 1);
    stepN(50);
    chk(irqPending == 1'b1, "R8 sticky idle", int'(irqPending), 1);
    evCount = 0;
    btnRaw = 1'b1;
    stepN(LAT + 2);
    btnRaw = 1'b0;
    stepN(LAT + 8);
    chk(evCount == 1, "R8 second event", evCount, 1);
    chk(irqPending == 1'b1, "R8 sticky press", int'(irqPending), 1);

    // R1: asynchronous reset mid-press
    btnRaw = 1'b1;
    stepN(LAT - 1);
    #2 rst = 1'b1;
    #1;
    chk(irqPending == 1'b0, "R1 async pending", int'(irqPending), 0);
    chk(irqPulse == 1'b0, "R1 async pulse", int'(irqPulse), 0);
    btnRaw = 1'b0;
    stepN(3);
    rst = 1'b0;
    evCount = 0;
    stepN(LAT + 8);
    chk(evCount == 0, "R1 history cleared", evCount, 0);

    finishRun();
  end

endmodule